// File: doc/BRIEF.md
# Three-Source Maskable Interrupt Controller

This block keeps the interrupt control register of a small 8-bit microcontroller and decides when the control unit must take a vectored interrupt. Three sources feed it: an external interrupt pin, a one-cycle overflow pulse from the system timer, and any change on the upper four pins of an input port. Each source has a sticky request flag and a private enable bit, and a global enable gates the whole set.

The control unit reads and writes the register through a simple write strobe and an always-valid read bus. It also pulses `port_rd` whenever software reads the input port. When `irq_req` is high, the control unit acknowledges, pushes its return address and jumps to the fixed vector on `irq_vector`. The acknowledge clears the global enable, so interrupts cannot nest. A return-from-interrupt pulse sets the global enable again. Hardware never clears a flag; software must do that.

The external pin and the port pins are asynchronous and pass through a synchronizer chain first. The timer pulse is already synchronous to `clk`.

Top module: `irq_ctrl_top`

## Requirements
- R1: After a synchronous active-low reset, `reg_rdata` reads 8'h00 and `irq_req` is low.
- R2: Register bits are: 7 global enable, 5 timer enable, 4 pin enable, 3 port-change enable, 2 timer flag, 1 pin flag, 0 port-change flag. Bit 6 always reads 0. A write with `reg_wr` high is visible on `reg_rdata` at the next clock edge.
- R3: A rising edge on `ext_pin` sets the pin flag at the third rising clock edge after the pin goes high (two synchronizer stages plus one flag register), and not earlier.
- R4: A one-cycle `tmr_ovf` pulse sets the timer flag at the next clock edge.
- R5: The port-change flag is set while the synchronized `port_hi` value differs from the snapshot taken at the last `port_rd` pulse. The snapshot is 4'h0 after reset, and the flag rises at the third edge after the pins change.
- R6: Each flag is set by its event whatever the state of its enable bit and of the global enable.
- R7: Only a register write can clear a flag. If an event and a write of 0 to the same flag fall in the same cycle, the flag ends up at 1.
- R8: `irq_req` equals the global enable ANDed with the OR over the three sources of flag AND enable. It follows the register contents with no added delay.
- R9: An `irq_ack` pulse clears the global enable at the next edge. The acknowledge takes priority over a simultaneous `irq_ret` and over a simultaneous write.
- R10: An `irq_ret` pulse without an acknowledge sets the global enable at the next edge. The other bits are left unchanged.
- R11: `irq_vector` is constantly 16'h0004.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer overflow pulse, one clock wide |
| port_hi | input | 4 | Asynchronous upper pins of the input port |
| port_rd | input | 1 | Pulse when software reads the port; takes a new snapshot |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current control register contents |
| irq_ack | input | 1 | Control unit is taking the interrupt |
| irq_ret | input | 1 | Return from interrupt |
| irq_req | output | 1 | Interrupt request to the control unit |
| irq_vector | output | 16 | Interrupt vector address |

## Verification
Every register bit reaches `reg_rdata` directly, so a wrong flag, enable or global-enable bit shows on the read bus at the first sample after the edge that corrupted it. Any such error that changes the gating shows on `irq_req` in the same cycle. A wrong snapshot or a wrong synchronizer depth shows up differently: the port or pin flag rises a cycle early or late, or not at all. The bench therefore samples both the cycle before and the cycle of the expected rise. All 128 combinations of global enable, enables and flags are swept against the arithmetic request equation. All fifteen non-zero port patterns are applied against the snapshot.

// File: rtl/irq_pkg.sv
// Package: shared parameters, bit positions and the per-source type for the
// interrupt controller. Assumes an 8-bit control register.
package irq_pkg;
    localparam int REG_W      = 8;
    localparam int POS_GIE    = 7;
    localparam int POS_EN_TMR = 5;
    localparam int POS_EN_EXT = 4;
    localparam int POS_EN_PRT = 3;
    localparam int POS_FL_TMR = 2;
    localparam int POS_FL_EXT = 1;
    localparam int POS_FL_PRT = 0;

    // One bit per source, ordered timer, pin, port (matches register order).
    typedef struct packed {
        logic tmr;
        logic ext;
        logic prt;
    } src_t;
endpackage

// File: rtl/irq_sync.sv
// Module: multi-stage synchronizer for asynchronous inputs.
// Assumes STAGES >= 2; all stages reset to zero.
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    // First stage samples the raw input.
    always_ff @(posedge clk) begin
        if (!rst_n) stage[0] <= '0;
        else        stage[0] <= d;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_chain
            // Each later stage copies its predecessor.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[i] <= '0;
                else        stage[i] <= stage[i-1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/irq_src_detect.sv
// Module: turns the three raw sources into one-cycle (or level) set requests.
// The pin request is a synchronized rising edge. The timer pulse passes through
// unchanged. The port request stays high while the synchronized pins differ
// from the snapshot taken at the last port read.
module irq_src_detect #(
    parameter int PORT_PINS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_pin,
    input  logic                 tmr_ovf,
    input  logic [PORT_PINS-1:0] port_hi,
    input  logic                 port_rd,
    output irq_pkg::src_t        set_req
);
    logic                 ext_s;
    logic                 ext_prev;
    logic [PORT_PINS-1:0] port_s;
    logic [PORT_PINS-1:0] snap;

    irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s)
    );

    irq_sync #(.W(PORT_PINS), .STAGES(SYNC_STAGES)) u_port_sync (
        .clk(clk), .rst_n(rst_n), .d(port_hi), .q(port_s)
    );

    // Remember the previous synchronized pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev <= 1'b0;
        else        ext_prev <= ext_s;
    end

    // Snapshot of the port pins, refreshed on every port read.
    always_ff @(posedge clk) begin
        if (!rst_n)       snap <= '0;
        else if (port_rd) snap <= port_s;
    end

    // Combine the three raw event conditions.
    always_comb begin
        set_req.ext = ext_s & ~ext_prev;
        set_req.tmr = tmr_ovf;
        set_req.prt = (port_s != snap);
    end

    // R5
    snap_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd |=> !set_req.prt || (port_s != $past(port_s)));

    // R3
    ext_edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req.ext |=> !set_req.ext);
endmodule

// File: rtl/irq_ctrl_reg.sv
// Module: the interrupt control register. It holds the global enable, three
// source enables and three sticky flags. Flags are set by events and cleared
// only by writes; an event wins over a clearing write. The acknowledge clears
// the global enable with top priority; the return pulse sets it.
module irq_ctrl_reg (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [irq_pkg::REG_W-1:0]   reg_wdata,
    input  logic                        irq_ack,
    input  logic                        irq_ret,
    input  irq_pkg::src_t               set_req,
    output logic                        gie,
    output irq_pkg::src_t               en,
    output irq_pkg::src_t               flag,
    output logic [irq_pkg::REG_W-1:0]   reg_rdata
);
    import irq_pkg::*;

    logic unused_bit6;
    assign unused_bit6 = reg_wdata[6];

    // Global enable: write, then return sets, then acknowledge clears.
    always_ff @(posedge clk) begin
        if (!rst_n)       gie <= 1'b0;
        else if (irq_ack) gie <= 1'b0;
        else if (irq_ret) gie <= 1'b1;
        else if (reg_wr)  gie <= reg_wdata[POS_GIE];
    end

    // Source enables change only on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) en <= '0;
        else if (reg_wr) begin
            en.tmr <= reg_wdata[POS_EN_TMR];
            en.ext <= reg_wdata[POS_EN_EXT];
            en.prt <= reg_wdata[POS_EN_PRT];
        end
    end

    // Sticky flags: a write loads them, an event forces them to 1.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else begin
            flag.tmr <= set_req.tmr | (reg_wr ? reg_wdata[POS_FL_TMR] : flag.tmr);
            flag.ext <= set_req.ext | (reg_wr ? reg_wdata[POS_FL_EXT] : flag.ext);
            flag.prt <= set_req.prt | (reg_wr ? reg_wdata[POS_FL_PRT] : flag.prt);
        end
    end

    // Assemble the read view; bit 6 reads zero.
    always_comb begin
        reg_rdata             = '0;
        reg_rdata[POS_GIE]    = gie;
        reg_rdata[POS_EN_TMR] = en.tmr;
        reg_rdata[POS_EN_EXT] = en.ext;
        reg_rdata[POS_EN_PRT] = en.prt;
        reg_rdata[POS_FL_TMR] = flag.tmr;
        reg_rdata[POS_FL_EXT] = flag.ext;
        reg_rdata[POS_FL_PRT] = flag.prt;
    end

    // R9
    ack_clears_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !gie);

    // R10
    ret_sets_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack) |=> gie);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag.tmr && !reg_wr) |=> flag.tmr);

    // R4
    tmr_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_req.tmr |=> flag.tmr);
endmodule

// File: rtl/irq_req_gen.sv
// Module: request generation. Combines flags, enables and the global enable
// into the request line and drives the fixed vector. Purely combinational.
module irq_req_gen #(
    parameter int          VEC_W    = 16,
    parameter logic [15:0] VEC_ADDR = 16'h0004
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gie,
    input  irq_pkg::src_t en,
    input  irq_pkg::src_t flag,
    output logic          irq_req,
    output logic [VEC_W-1:0] irq_vector
);
    // Gate each flag with its enable, then with the global enable.
    always_comb begin
        irq_req    = gie & |(en & flag);
        irq_vector = VEC_W'(VEC_ADDR);
    end

    // R8
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (gie && (flag != '0)));
endmodule

// File: rtl/irq_ctrl_top.sv
// Module: top of the three-source interrupt controller. Wires source
// detection, the control register and request generation together.
// Assumes the control unit asserts irq_ack only while irq_req is high.
module irq_ctrl_top #(
    parameter int          PORT_PINS   = 4,
    parameter int          SYNC_STAGES = 2,
    parameter int          VEC_W       = 16,
    parameter logic [15:0] VEC_ADDR    = 16'h0004
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ext_pin,
    input  logic                 tmr_ovf,
    input  logic [PORT_PINS-1:0] port_hi,
    input  logic                 port_rd,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 irq_ack,
    input  logic                 irq_ret,
    output logic                 irq_req,
    output logic [VEC_W-1:0]     irq_vector
);
    irq_pkg::src_t set_req;
    irq_pkg::src_t en;
    irq_pkg::src_t flag;
    logic          gie;

    irq_src_detect #(.PORT_PINS(PORT_PINS), .SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .port_hi(port_hi), .port_rd(port_rd), .set_req(set_req)
    );

    irq_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .set_req(set_req),
        .gie(gie), .en(en), .flag(flag), .reg_rdata(reg_rdata)
    );

    irq_req_gen #(.VEC_W(VEC_W), .VEC_ADDR(VEC_ADDR)) u_req (
        .clk(clk), .rst_n(rst_n), .gie(gie), .en(en), .flag(flag),
        .irq_req(irq_req), .irq_vector(irq_vector)
    );

    // R11
    vector_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vector == VEC_W'(16'h0004));
endmodule

// File: tb/irq_ctrl_top_test.sv
module irq_ctrl_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic [3:0] port_hi = 4'h0;
    logic       port_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;
    logic [15:0] irq_vector;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_ctrl_top uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .port_hi(port_hi), .port_rd(port_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .irq_req(irq_req), .irq_vector(irq_vector)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1 reg", reg_rdata, 8'h00);
        chk("R1 req", irq_req, 1'b0);
        chk("R11 vector", irq_vector, 16'h0004);

        // R2 R8: sweep all gie/enable/flag combinations
        for (int c = 0; c < 128; c++) begin
            logic [7:0] d;
            d = {c[6], c[0], c[5:0]};
            wr(d);
            chk("R2 readback", reg_rdata, d & 8'hBF);
            chk("R8 req", irq_req, d[7] & |(d[5:3] & d[2:0]));
        end

        // R4 R6: timer pulse with everything disabled
        wr(8'h00);
        tmr_ovf = 1'b1; step(1); tmr_ovf = 1'b0;
        chk("R4 R6 timer flag", reg_rdata, 8'h04);
        chk("R6 no req", irq_req, 1'b0);
        step(2);
        chk("R7 flag sticky", reg_rdata, 8'h04);

        // R7: event and clearing write in the same cycle
        tmr_ovf = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h00;
        step(1);
        tmr_ovf = 1'b0; reg_wr = 1'b0;
        chk("R7 event wins", reg_rdata, 8'h04);
        wr(8'h00);
        chk("R7 write clears", reg_rdata, 8'h00);

        // R3: pin rising edge latency
        ext_pin = 1'b1;
        step(2);
        chk("R3 not early", reg_rdata[1], 1'b0);
        step(1);
        chk("R3 pin flag", reg_rdata[1], 1'b1);
        wr(8'h00);
        step(3);
        chk("R3 level no reset", reg_rdata[1], 1'b0);
        ext_pin = 1'b0;
        step(4);
        chk("R3 falling ignored", reg_rdata[1], 1'b0);

        // R5: every non-zero port pattern against the zero snapshot
        for (int v = 1; v < 16; v++) begin
            port_hi = 4'(v);
            step(2);
            chk("R5 not early", reg_rdata[0], 1'b0);
            step(1);
            chk("R5 port flag", reg_rdata[0], 1'b1);
            port_rd = 1'b1; step(1); port_rd = 1'b0;
            wr(8'h00);
            step(2);
            chk("R5 snapshot match", reg_rdata[0], 1'b0);
            port_hi = 4'h0;
            step(3);
            chk("R5 back to zero", reg_rdata[0], 1'b1);
            port_rd = 1'b1; step(1); port_rd = 1'b0;
            wr(8'h00);
            step(2);
        end

        // R9 R10: acknowledge and return
        wr(8'hA4);
        chk("R8 req on", irq_req, 1'b1);
        irq_ack = 1'b1; step(1); irq_ack = 1'b0;
        chk("R9 ack clears gie", reg_rdata, 8'h24);
        chk("R9 req off", irq_req, 1'b0);
        irq_ret = 1'b1; step(1); irq_ret = 1'b0;
        chk("R10 ret sets gie", reg_rdata, 8'hA4);
        irq_ack = 1'b1; irq_ret = 1'b1; step(1); irq_ack = 1'b0; irq_ret = 1'b0;
        chk("R9 ack over ret", reg_rdata, 8'h24);
        irq_ack = 1'b1; reg_wr = 1'b1; reg_wdata = 8'hB4;
        step(1);
        irq_ack = 1'b0; reg_wr = 1'b0;
        chk("R9 ack over write", reg_rdata, 8'h34);
        chk("R11 vector", irq_vector, 16'h0004);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule